// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank with Sync-Aligned Commit

This block sits behind a serial configuration receiver. The receiver gives it one write strobe per 6-bit word, with the word's address. The block keeps a staging copy of every register and a live copy that drives the rest of the chip. Writes collect in staging while the frame-select line `sl` is low. The rising edge of `sl` ends the frame and moves the written words forward. A per-address parameter table gives each address a kind and an update class. The kind is single, low half or high half of a 12-bit pair. The class is frame-commit or sync-commit.

Frame-commit registers go live on the clock after `sl` rises. Sync-commit registers are first held in a preload copy. They go live on a chosen horizontal-sync (`hd`) falling edge, counted from the first vertical-sync (`vd`) falling edge after the preload. The line index comes from the live value at address `UPD_ADDR`, which is 15 by default. Both `vd` and `hd` pass through two-flop synchronizers before their falling edges are detected.

A sequencer with three named states controls the sync commit:
- **UPD_IDLE**: nothing is waiting. It moves to UPD_WAIT_VD once a sync-class word has been preloaded.
- **UPD_WAIT_VD**: waits for a `vd` fall. On that fall it arms all preloaded words, clears the line counter and moves to UPD_COUNT_HD.
- **UPD_COUNT_HD**: counts `hd` falls. When the count equals the line index, it fires, commits the armed words, and returns to UPD_WAIT_VD if newer preloads exist or to UPD_IDLE if not. A `vd` fall seen in this state re-arms and restarts the count.

Top module: `sbank_shadow_bank`

## Requirements
- R1: After reset every live register reads 0. Address a is presented on `act_regs[6*a+5 : 6*a]`.
- R2: A word written to a single, frame-class address leaves the live value unchanged while `sl` stays low. It appears on the clock edge after `sl` rises.
- R3: A 12-bit pair keeps bits 5:0 at the low address (0 and 4 by default) and bits 11:6 at the next address up. Writing the low half and then the high half in one frame updates both live halves at the same commit.
- R4: Writing only the low half of a pair never changes either live half, at that frame end or at any later one.
- R5: Writing only the high half commits the whole pair. The low half takes whatever value was last written to its staging slot, even if that write was in an earlier frame.
- R6: Halves commit in write order. For the order low A, high B, low C, the commit carries A and B. C stays staged and goes live together with the next high-half write.
- R7: A sync-class word (addresses 3, 4 and 5 by default) does not change at the frame end. It goes live on `hd` fall number N after the next `vd` fall, where N is the live value at address 15 and N = 0 means the first such `hd` fall. `hd` falls seen before that `vd` fall are not counted.
- R8: A sync-class word preloaded after the `vd` fall that armed an earlier update waits for a later `vd` fall. The pending update does not carry it.
- R9: Addresses not written in a frame keep their live values across every commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle strobe for one received word |
| wr_addr | input | 4 | Register address of the word |
| wr_data | input | 6 | Data word |
| sl | input | 1 | Frame select, low during a frame; its rising edge ends the frame |
| vd | input | 1 | Vertical sync, asynchronous, falling edge is active |
| hd | input | 1 | Horizontal sync, asynchronous, falling edge is active |
| act_regs | output | 96 | Live register values, 6 bits per address |

## Verification
The bench goes after the pair-ordering cases: a low half with no high half, a high half alone with a stale low slot, and a low-high-low sequence. A design that got these wrong would commit a half-written pair, or would pick up the later low word. For the sync path, the bench sends `hd` falls before the `vd` fall and varies the line index from 0 to 3. A wrong design would go live one line early or late, or would count lines from before the field. The bench also preloads new sync data while an update is counting. A design that folds that data into the pending commit would release it one field too early.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_LOW    = 2'd1,
        KIND_HIGH   = 2'd2
    } reg_kind_e;

    typedef enum logic [1:0] {
        UPD_IDLE     = 2'd0,
        UPD_WAIT_VD  = 2'd1,
        UPD_COUNT_HD = 2'd2
    } upd_state_e;
endpackage

// File: rtl/sbank_edge_sync.sv
module sbank_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign fall = last_q & ~sync_q;
endmodule

// File: rtl/sbank_shadow.sv
module sbank_shadow
    import sbank_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 6,
    parameter int AW   = $clog2(NREG),
    parameter logic [2*NREG-1:0] KIND_MAP = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               sl,
    output logic               sl_rise,
    output logic [NREG-1:0]    pend,
    output logic [NREG*DW-1:0] cand_flat,
    output logic [NREG*DW-1:0] pre_flat
);
    logic sl_q;
    logic [DW-1:0] stage_q [NREG];
    logic [DW-1:0] cand_q  [NREG];
    logic [DW-1:0] pre_q   [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= 1'b1;
        else        sl_q <= sl;
    end
    assign sl_rise = sl & ~sl_q;

    for (genvar a = 0; a < NREG; a++) begin : g_slot
        localparam reg_kind_e KIND = reg_kind_e'(KIND_MAP[2*a +: 2]);
        logic hit, set_pend;

        assign hit = wr_stb && (wr_addr == AW'(a));

        if (KIND == KIND_LOW) begin : g_low
            logic hit_up;
            assign hit_up   = wr_stb && (wr_addr == AW'(a + 1));
            assign set_pend = hit_up;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cand_q[a] <= '0;
                else if (hit_up) cand_q[a] <= stage_q[a];
            end
        end else begin : g_direct
            assign set_pend = hit;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   cand_q[a] <= '0;
                else if (hit) cand_q[a] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[a] <= '0;
                pre_q[a]   <= '0;
                pend[a]    <= 1'b0;
            end else begin
                if (hit) stage_q[a] <= wr_data;
                if (sl_rise && pend[a]) pre_q[a] <= cand_q[a];
                if (set_pend)     pend[a] <= 1'b1;
                else if (sl_rise) pend[a] <= 1'b0;
            end
        end

        assign cand_flat[a*DW +: DW] = cand_q[a];
        assign pre_flat[a*DW +: DW]  = pre_q[a];

        if (KIND == KIND_HIGH && a > 0) begin : g_pair_chk
            assert_pair_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
                pend[a] |-> pend[a-1]);
        end
    end

    // R4: pending marks never survive a frame end unless rewritten
    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_rise && !wr_stb) |=> (pend == '0));
endmodule

// File: rtl/sbank_sync_fsm.sv
module sbank_sync_fsm
    import sbank_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vd_fall,
    input  logic            hd_fall,
    input  logic [NREG-1:0] sync_load,
    input  logic [DW-1:0]   hd_target,
    output logic            fire,
    output logic [NREG-1:0] arm_mask
);
    upd_state_e      state_q, state_d;
    logic [NREG-1:0] new_q, new_d, arm_q, arm_d;
    logic [DW-1:0]   hcnt_q, hcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_q  <= '0;
            arm_q  <= '0;
            hcnt_q <= '0;
        end else begin
            new_q  <= new_d;
            arm_q  <= arm_d;
            hcnt_q <= hcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        new_d   = new_q | sync_load;
        arm_d   = arm_q;
        hcnt_d  = hcnt_q;
        unique case (state_q)
            UPD_IDLE: begin
                if (new_q != '0) state_d = UPD_WAIT_VD;
            end
            UPD_WAIT_VD: begin
                if (vd_fall) begin
                    arm_d   = arm_q | new_q;
                    new_d   = sync_load;
                    hcnt_d  = '0;
                    state_d = UPD_COUNT_HD;
                end
            end
            UPD_COUNT_HD: begin
                if (vd_fall) begin
                    arm_d  = arm_q | new_q;
                    new_d  = sync_load;
                    hcnt_d = '0;
                end else if (hd_fall) begin
                    if (hcnt_q == hd_target) begin
                        fire    = 1'b1;
                        arm_d   = '0;
                        state_d = (new_d != '0) ? UPD_WAIT_VD : UPD_IDLE;
                    end else begin
                        hcnt_d = hcnt_q + 1'b1;
                    end
                end
            end
            default: state_d = UPD_IDLE;
        endcase
    end

    assign arm_mask = arm_q;

    assert_wait_no_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_WAIT_VD) |-> !fire);
    assert_fire_on_hd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> hd_fall);
    assert_idle_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_IDLE) |-> (arm_q == '0));
endmodule

// File: rtl/sbank_shadow_bank.sv
module sbank_shadow_bank #(
    parameter int NREG     = 16,
    parameter int DW       = 6,
    parameter int AW       = $clog2(NREG),
    parameter int UPD_ADDR = NREG - 1,
    parameter logic [2*NREG-1:0] KIND_MAP = 32'h0000_0909,
    parameter logic [NREG-1:0]   SYNC_MAP = 16'h0038
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               sl,
    input  logic               vd,
    input  logic               hd,
    output logic [NREG*DW-1:0] act_regs
);
    logic               vd_fall, hd_fall, sl_rise, fire;
    logic [NREG-1:0]    pend, arm_mask, frame_set, sync_load;
    logic [NREG*DW-1:0] cand_flat, pre_flat;

    sbank_edge_sync u_vd_sync (.clk(clk), .rst_n(rst_n), .async_in(vd), .fall(vd_fall));
    sbank_edge_sync u_hd_sync (.clk(clk), .rst_n(rst_n), .async_in(hd), .fall(hd_fall));

    sbank_shadow #(.NREG(NREG), .DW(DW), .AW(AW), .KIND_MAP(KIND_MAP)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .sl(sl), .sl_rise(sl_rise), .pend(pend),
        .cand_flat(cand_flat), .pre_flat(pre_flat)
    );

    assign frame_set = sl_rise ? (pend & ~SYNC_MAP) : '0;
    assign sync_load = sl_rise ? (pend &  SYNC_MAP) : '0;

    sbank_sync_fsm #(.NREG(NREG), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vd_fall(vd_fall), .hd_fall(hd_fall),
        .sync_load(sync_load), .hd_target(act_regs[UPD_ADDR*DW +: DW]),
        .fire(fire), .arm_mask(arm_mask)
    );

    for (genvar a = 0; a < NREG; a++) begin : g_live
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   act_regs[a*DW +: DW] <= '0;
            else if (frame_set[a])        act_regs[a*DW +: DW] <= cand_flat[a*DW +: DW];
            else if (fire && arm_mask[a]) act_regs[a*DW +: DW] <= pre_flat[a*DW +: DW];
        end
    end

    // R2/R9: live values move only on a frame end or a sync commit
    assert_live_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sl_rise && !fire) |=> $stable(act_regs));
endmodule

// File: tb/sbank_shadow_bank_test.sv
module sbank_shadow_bank_test;
    localparam int N = 16;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_stb = 1'b0, sl = 1'b1, vd = 1'b1, hd = 1'b1;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [95:0] act_regs;

    int n_chk = 0, n_fail = 0;
    int mstage[N], mcand[N], mpend[N], mpre[N], mnew[N], marm[N], mact[N];
    int mst = 0, mh = 0;
    bit in_frame = 0;

    always #10 clk = ~clk;

    sbank_shadow_bank uut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .sl(sl), .vd(vd), .hd(hd), .act_regs(act_regs));

    function automatic int kind_of(int a);
        if (a == 0 || a == 4) return 1;
        if (a == 1 || a == 5) return 2;
        return 0;
    endfunction

    function automatic bit sync_of(int a);
        return (a >= 3 && a <= 5);
    endfunction

    function automatic bit any_new();
        for (int a = 0; a < N; a++) if (mnew[a] != 0) return 1;
        return 0;
    endfunction

    task automatic check_all(string tag);
        n_chk++;
        for (int a = 0; a < N; a++) begin
            if (int'(act_regs[a*6 +: 6]) != mact[a]) begin
                n_fail++;
                $display("FAIL %s addr %0d actual %0h expected %0h", tag, a, act_regs[a*6 +: 6], mact[a]);
                break;
            end
        end
    endtask

    task automatic check_val(string tag, int a, int exp);
        n_chk++;
        if (int'(act_regs[a*6 +: 6]) != exp) begin
            n_fail++;
            $display("FAIL %s addr %0d actual %0h expected %0h", tag, a, act_regs[a*6 +: 6], exp);
        end
    endtask

    task automatic do_write(int a, int d);
        if (!in_frame) begin
            sl = 1'b0; in_frame = 1;
            @(negedge clk);
        end
        wr_stb = 1'b1; wr_addr = 4'(a); wr_data = 6'(d);
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        case (kind_of(a))
            0: begin mstage[a] = d; mcand[a] = d; mpend[a] = 1; end
            1: mstage[a] = d;
            default: begin
                mstage[a] = d; mcand[a] = d; mcand[a-1] = mstage[a-1];
                mpend[a] = 1; mpend[a-1] = 1;
            end
        endcase
    endtask

    task automatic frame_end();
        if (!in_frame) begin
            sl = 1'b0; @(negedge clk);
        end
        sl = 1'b1; in_frame = 0;
        repeat (2) @(negedge clk);
        for (int a = 0; a < N; a++) begin
            if (mpend[a] != 0) begin
                mpre[a] = mcand[a];
                if (sync_of(a)) mnew[a] = 1; else mact[a] = mcand[a];
            end
            mpend[a] = 0;
        end
        if (mst == 0 && any_new()) mst = 1;
    endtask

    task automatic vd_pulse();
        vd = 1'b0; repeat (4) @(negedge clk);
        vd = 1'b1; repeat (4) @(negedge clk);
        if (mst != 0) begin
            for (int a = 0; a < N; a++) begin
                if (mnew[a] != 0) marm[a] = 1;
                mnew[a] = 0;
            end
            mh = 0; mst = 2;
        end
    endtask

    task automatic hd_pulse();
        hd = 1'b0; repeat (4) @(negedge clk);
        hd = 1'b1; repeat (4) @(negedge clk);
        if (mst == 2) begin
            if (mh == mact[15]) begin
                for (int a = 0; a < N; a++) begin
                    if (marm[a] != 0) mact[a] = mpre[a];
                    marm[a] = 0;
                end
                mst = any_new() ? 1 : 0;
            end else mh = (mh + 1) % 64;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) begin
            mstage[a] = 0; mcand[a] = 0; mpend[a] = 0; mpre[a] = 0;
            mnew[a] = 0; marm[a] = 0; mact[a] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: single frame-class word
        do_write(2, 6'h15); check_val("R2 before frame end", 2, 0);
        frame_end();        check_val("R2 after frame end", 2, 6'h15);

        // R3: pair written in order
        do_write(0, 6'h2A); do_write(1, 6'h11);
        check_val("R3 hold low", 0, 0);
        frame_end();
        check_val("R3 low half", 0, 6'h2A); check_val("R3 high half", 1, 6'h11);

        // R4: low half alone
        do_write(0, 6'h05); frame_end();
        check_val("R4 low untouched", 0, 6'h2A); check_val("R4 high untouched", 1, 6'h11);
        frame_end(); check_val("R4 later frame", 0, 6'h2A);

        // R5: high half alone uses stale low slot
        do_write(1, 6'h3F); frame_end();
        check_val("R5 stale low", 0, 6'h05); check_val("R5 high", 1, 6'h3F);

        // R6: low, high, low order
        do_write(0, 6'h01); do_write(1, 6'h02); do_write(0, 6'h03); frame_end();
        check_val("R6 first low kept", 0, 6'h01); check_val("R6 high", 1, 6'h02);
        do_write(1, 6'h04); frame_end();
        check_val("R6 second low later", 0, 6'h03);
        check_all("R9 untouched addresses");

        // R7: sync update on line 2 after the next VD fall
        do_write(15, 2); frame_end(); check_val("R7 line index", 15, 2);
        do_write(3, 6'h22); frame_end(); check_val("R7 no change at frame end", 3, 0);
        hd_pulse(); check_val("R7 HD before VD ignored", 3, 0);
        vd_pulse(); hd_pulse(); check_val("R7 line 0", 3, 0);
        hd_pulse(); check_val("R7 line 1", 3, 0);
        hd_pulse(); check_val("R7 line 2 commit", 3, 6'h22);

        // R8: preload during counting waits a field
        do_write(15, 1); frame_end();
        do_write(3, 6'h0A); frame_end(); vd_pulse();
        do_write(4, 6'h31); do_write(5, 6'h1C); frame_end();
        hd_pulse(); check_val("R8 line 0", 3, 6'h22);
        hd_pulse(); check_val("R8 commit", 3, 6'h0A); check_val("R8 late pair held", 4, 0);
        vd_pulse(); hd_pulse(); check_val("R8 pair line 0", 5, 0);
        hd_pulse(); check_val("R8 pair low", 4, 6'h31); check_val("R8 pair high", 5, 6'h1C);
        check_all("R9 after sync");

        // random mix checked against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(99));
            if (r < 45) begin
                int a;
                a = int'($urandom_range(15));
                do_write(a, (a == 15) ? int'($urandom_range(3)) : int'($urandom_range(63)));
            end else if (r < 62) frame_end();
            else if (r < 72) vd_pulse();
            else hd_pulse();
            check_all("R9 random mix");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule